// File: doc/BRIEF.md
# Entropy Seed Register

This block stands in front of a raw noise source and presents it to a processor as one read-only seed register. Raw bits arrive one at a time on a valid-qualified input. After reset the block first runs a startup self-test lasting a fixed number of cycles. It then packs incoming bits into 16-bit samples and hands each sample out exactly once. Every read word carries a 2-bit operational status in its top bits, so software can poll the register and act on what it finds.

The processor access is a single read strobe. The access is architecturally a read-and-write, but the write half carries no meaning and its data is discarded. A simple online repetition-count health test watches the raw stream. When the stream sticks at one value for too long, the block enters a failure status that only reset can clear.

Top module: `entropy_seed_reg`

## Requirements
- R1: The read word `rd_data` holds the status in bits 31:30, encoded 00 = self-test running, 01 = waiting for entropy, 10 = sample ready, 11 = unrecoverable failure. Bits 29:16 always read as zero. During and just after reset the word is all zeros.
- R2: After reset is released, the status reads 00 for exactly `SELFTEST_CYCLES` clock edges and then becomes 01.
- R3: Raw bits that arrive while the status is 00 are discarded. They are not packed into a sample and they are not seen by the repetition test.
- R4: While the status is 01, each valid raw bit is shifted into the sample at bit 0, so the first of the 16 bits ends up in bit 15. The clock edge that takes the 16th bit moves the status to 10, and bits 15:0 then show the sample.
- R5: Bits 15:0 read as zero whenever the status is not 10.
- R6: A read strobe taken while the status is 10 consumes the sample. The status returns to 01, and 16 fresh bits are needed before it reads 10 again.
- R7: A read strobe while the status is 01 leaves the number of bits already gathered and their values unchanged.
- R8: While the status is 10, arriving raw bits are not packed, and the held sample stays unchanged until it is read.
- R9: The value on `wr_data` has no effect on the block.
- R10: Outside the self-test, the repetition test counts consecutive valid raw bits of equal value, including across sample boundaries and while the status is 10. The edge that takes the `REP_LIMIT`-th equal bit in a row moves the status to 11. That edge takes priority over sample completion and over consumption.
- R11: Once the status is 11 it stays 11 until reset, whatever the raw input or the read strobe does, and bits 15:0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_valid | input | 1 | A raw entropy bit is present on `raw_bit` this cycle |
| raw_bit | input | 1 | Raw entropy bit |
| rd_en | input | 1 | Read strobe for the seed register; a ready sample is consumed at this edge |
| wr_data | input | 32 | Write half of the access; discarded |
| rd_data | output | 32 | Status-tagged seed word, valid throughout the cycle in which `rd_en` is raised |

## Verification
The checker evaluates the status-transition rules on every cycle. It confirms that the self-test window has exactly the configured length, that status 00 never returns once it is left, and that failure is sticky. It also confirms that a consumed sample always drops out of status 10, that a ready sample stays frozen until it is read, that status 01 cannot advance without a raw bit, and that the idle fields stay zero. Some behaviour only the bench's scenarios can show: the exact bit order inside a sample, the discarding of bits during the self-test, a poll in the middle of gathering that leaves progress intact, and the repetition count crossing a sample boundary or running while a sample waits.

// File: rtl/entropy_seed_reg.sv
`timescale 1ns/1ps
module entropy_seed_reg #(
  parameter int SELFTEST_CYCLES = 256,
  parameter int REP_LIMIT       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        raw_valid,
  input  logic        raw_bit,
  input  logic        rd_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam int SW = 16;
  localparam int CW = $clog2(SELFTEST_CYCLES + 1);
  localparam int RW = $clog2(REP_LIMIT + 1);
  localparam int FW = $clog2(SW + 1);

  typedef enum logic [1:0] {
    ST_TEST  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_READY = 2'b10,
    ST_FAIL  = 2'b11
  } status_t;

  status_t        st, st_nx;
  logic [CW-1:0]  test_cnt;
  logic [RW-1:0]  run_len, run_nx;
  logic           last_bit;
  logic [FW-1:0]  fill;
  logic [SW-1:0]  sample;
  logic           live, stuck, take_bit, unused_wr;

  assign unused_wr = ^wr_data;
  assign live      = (st == ST_WAIT) || (st == ST_READY);
  assign run_nx    = (run_len != '0 && raw_bit == last_bit) ? run_len + RW'(1) : RW'(1);
  assign stuck     = live && raw_valid && (run_nx == RW'(REP_LIMIT));
  assign take_bit  = (st == ST_WAIT) && raw_valid;

  always_comb begin
    st_nx = st;
    case (st)
      ST_TEST:  if (test_cnt == CW'(SELFTEST_CYCLES - 1)) st_nx = ST_WAIT;
      ST_WAIT:  if (take_bit && fill == FW'(SW - 1)) st_nx = ST_READY;
      ST_READY: if (rd_en) st_nx = ST_WAIT;
      default:  st_nx = ST_FAIL;
    endcase
    if (stuck) st_nx = ST_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_TEST;
      test_cnt <= '0;
      run_len  <= '0;
      last_bit <= 1'b0;
      fill     <= '0;
      sample   <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_TEST && test_cnt != CW'(SELFTEST_CYCLES - 1))
        test_cnt <= test_cnt + CW'(1);
      if (live && raw_valid) begin
        run_len  <= run_nx;
        last_bit <= raw_bit;
      end
      if (take_bit) begin
        sample <= {sample[SW-2:0], raw_bit};
        fill   <= fill + FW'(1);
      end
      if (st == ST_READY && rd_en) fill <= '0;
    end
  end

  assign rd_data = {st, 14'd0, (st == ST_READY) ? sample : 16'd0};
endmodule

// File: rtl/entropy_seed_reg_chk.sv
`timescale 1ns/1ps
module entropy_seed_reg_chk #(
  parameter int SELFTEST_CYCLES = 256,
  parameter int REP_LIMIT       = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        raw_valid,
  input logic        rd_en,
  input logic [31:0] rd_data
);
  localparam int CW = $clog2(SELFTEST_CYCLES + 2);
  logic [CW-1:0] since;
  logic [1:0]    s;
  assign s = rd_data[31:30];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '0;
    else if (since != CW'(SELFTEST_CYCLES)) since <= since + CW'(1);

  p_test_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since < CW'(SELFTEST_CYCLES)) |-> (s == 2'b00));
  p_test_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since == CW'(SELFTEST_CYCLES)) |-> (s != 2'b00));
  p_mid_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29:16] == 14'd0);
  p_data_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s != 2'b10) |-> (rd_data[15:0] == 16'd0));
  p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s == 2'b10 && rd_en) |=> (s != 2'b10));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s == 2'b10 && !rd_en) |=> (s == 2'b11 || $stable(rd_data)));
  p_wait_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s == 2'b01 && !raw_valid) |=> (s == 2'b01));
  p_fail_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (s == 2'b11) |=> (s == 2'b11));
endmodule

bind entropy_seed_reg entropy_seed_reg_chk #(
  .SELFTEST_CYCLES(SELFTEST_CYCLES),
  .REP_LIMIT(REP_LIMIT)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .raw_valid(raw_valid),
  .rd_en(rd_en),
  .rd_data(rd_data)
);

// File: tb/entropy_seed_reg_tb.sv
`timescale 1ns/1ps
module entropy_seed_reg_tb;
  localparam int NT  = 20;
  localparam int REP = 6;
  localparam logic [31:0] W_TEST = 32'h0000_0000;
  localparam logic [31:0] W_WAIT = 32'h4000_0000;
  localparam logic [31:0] W_FAIL = 32'hC000_0000;
  localparam logic [15:0] VEC [4] = '{16'hA5C3, 16'h6D29, 16'h3C5A, 16'h9B4E};

  logic clk = 1'b0, rst_n = 1'b0, raw_valid = 1'b0, raw_bit = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = 32'h0, rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  entropy_seed_reg #(.SELFTEST_CYCLES(NT), .REP_LIMIT(REP)) u_dut (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bit(raw_bit),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data));

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); raw_valid = 1'b1; raw_bit = b;
    @(negedge clk); raw_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) send_bit(w[i]);
  endtask

  task automatic do_read(input logic [31:0] junk);
    @(negedge clk); rd_en = 1'b1; wr_data = junk;
    @(negedge clk); rd_en = 1'b0; wr_data = 32'h0;
  endtask

  task automatic reset_and_test(input bit feed_ones);
    @(negedge clk); rst_n = 1'b0; raw_valid = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset word", W_TEST);
    rst_n = 1'b1;
    if (feed_ones) begin raw_valid = 1'b1; raw_bit = 1'b1; end
    repeat (NT - 1) @(negedge clk);
    check("R2 still self-test", W_TEST);
    @(negedge clk);
    raw_valid = 1'b0;
    check("R2 self-test over", W_WAIT);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R3: ones streamed through the whole self-test would trip the repetition test if counted
    reset_and_test(1'b1);

    for (int v = 0; v < 4; v++) begin
      send_word(VEC[v], 15);
      check("R5 partial sample hidden", W_WAIT);
      send_bit(VEC[v][0]);
      check("R4 sample ready", {2'b10, 14'd0, VEC[v]});
      do_read(32'hFFFF_FFFF ^ 32'(v));
      check("R6 read consumes", W_WAIT);
    end

    // R8: bits arriving while a sample waits are not packed
    send_word(16'h5A5A, 16);
    check("R4 sample ready", 32'h8000_5A5A);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    check("R8 sample held", 32'h8000_5A5A);
    do_read(32'h1234_5678);
    check("R6 read consumes", W_WAIT);

    // R7 and R9: poll mid-gather with junk write data
    send_word(16'h9300, 8);
    do_read(32'hDEAD_BEEF);
    check("R7 poll while waiting", W_WAIT);
    send_word(16'h6C00, 8);
    check("R7 R9 progress kept", 32'h8000_936C);
    do_read(32'h0);

    // R10: repetition limit in waiting state
    for (int i = 0; i < REP - 1; i++) send_bit(1'b1);
    check("R10 below limit", W_WAIT);
    send_bit(1'b1);
    check("R10 limit reached", W_FAIL);
    // R11: sticky failure
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    do_read(32'hFFFF_FFFF);
    check("R11 failure sticky", W_FAIL);

    // R11 reset clears; R10 across sample boundary while ready
    reset_and_test(1'b0);
    send_word(16'h5555, 16);
    check("R4 sample ready", 32'h8000_5555);
    for (int i = 0; i < REP - 2; i++) send_bit(1'b1);
    check("R10 run below limit while ready", 32'h8000_5555);
    send_bit(1'b1);
    check("R10 limit across boundary", W_FAIL);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule